// File: doc/BRIEF.md
# Multi-mode PWM Submodule Generator

This block produces two pulse-width-modulated outputs, A and B, from one 16-bit counter. The counter is advanced by a power-of-two prescaler. It runs from a programmable start value up to a programmable end value and then returns to the start value. A mid-period value marks the centre of each period.

Each output has a turn-on compare and a turn-off compare. Compares can be placed in unsigned or in signed two's-complement space, so both edge-aligned and centre-aligned waveforms can be built. Software writes the seven period and compare values into a staging set. A separate load-request bit moves the staging set into the active set. The move happens at once, or at the half-cycle point, the full-cycle point, or both. A load-frequency field lets only every Nth such point take the load.

A and B can run independently, or as a complementary pair fed by one chosen compare pair. Each output has its own polarity inversion and its own enable.

Top module: `pwm_submod`

## Requirements
- R1: After reset both outputs are 0, the active and staged values are 0, and the load-request bit is clear.
- R2: While the run bit (control bit 12) is set, the counter goes up by one on each prescaled tick. After reaching the end value it returns to the start value. While run is clear, the counter is held at the start value and the internal A/B states are inactive, so in independent mode with no inversion both outputs are 0.
- R3: The prescaler gives one tick every 2^p clock cycles, where p is control bits [2:0].
- R4: An output's internal state goes active on the tick where the count becomes its turn-on compare. It goes inactive on the tick where the count becomes its turn-off compare. Turn-off wins, so equal compares give 0% duty. A uses staged addresses 3 (on) and 4 (off); B uses addresses 5 (on) and 6 (off).
- R5: Control bit 9 selects signed comparison for the wrap test (count at or beyond the end value). In signed mode, a negative start value lets the counter pass through zero, which gives centre-aligned pulses. In unsigned mode the same negative start is already beyond the end value, so the counter stays at the start value.
- R6: Writes to addresses 0..6 (0 start, 1 mid, 2 end, 3..6 compares) only change the staged set. They have no effect on the outputs until a load takes place.
- R7: Writing address 9 with data bit 0 set raises the load request. The load copies the whole staged set into the active set and clears the request. In buffered modes the request stays pending while no reload point occurs.
- R8: Control bits [4:3] choose the reload point: 0 immediate (next cycle, even while stopped), 1 the tick at which the count equals the mid value, 2 the wrap tick, 3 either.
- R9: With control bits [8:5] = N, the load takes place on every (N+1)th reload point. This counting starts from the moment run is set. The field is ignored in immediate mode.
- R10: Control bit 10 set makes A and B independent. When it is clear the pair is complementary. Control bit 11 then picks the source: 0 uses A's compare pair and drives B as its inverse; 1 uses B's compare pair and drives A as its inverse. The inversion is applied before polarity.
- R11: Address 8 holds the output settings: bit 0 inverts A, bit 1 inverts B, bit 2 enables A and bit 3 enables B. A disabled output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..9) |
| wr_data | input | 16 | Register write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
A wrong counter, start or end value shows up as a changed rise-to-rise interval on the very first full period, within one period of the prescaled count. A wrong load-request state or reload-opportunity count shows up as a pulse width that changes one or more periods too early or too late. For that reason the bench compares each pulse width in sequence against a precomputed list. A pairing or polarity fault shows up as wrong levels on the outputs within the same clock cycle.

// File: rtl/pwm_submod.sv
module pwm_submod #(
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int FQW = 4,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_a,
  output logic          out_b
);
  localparam int NREG = 7;
  localparam int PCW  = (1 << PSW) - 1;
  localparam int CTW  = 13;
  localparam int I_ST = 0, I_MID = 1, I_END = 2, I_AON = 3, I_AOFF = 4, I_BON = 5, I_BOFF = 6;
  localparam logic [AW-1:0] A_CTL = AW'(7), A_OUT = AW'(8), A_LDOK = AW'(9);

  logic [CW-1:0]  stg [NREG];
  logic [CW-1:0]  act [NREG];
  logic [CTW-1:0] ctl;
  logic [3:0]     octl;
  logic           load_ok;
  logic [PCW-1:0] pre;
  logic [CW-1:0]  cnt;
  logic [FQW-1:0] fq_cnt;
  logic           ra, rb;

  wire [PSW-1:0] ps    = ctl[PSW-1:0];
  wire [1:0]     lmode = ctl[4:3];
  wire [FQW-1:0] ldfq  = ctl[5 +: FQW];
  wire           sgn   = ctl[9];
  wire           indep = ctl[10];
  wire           src_b = ctl[11];
  wire           run   = ctl[12];
  wire           imm   = (lmode == 2'd0);

  wire [PCW-1:0] pre_lim = PCW'((1 << ps) - 1);
  wire tick = run && (pre == pre_lim);

  wire beyond = sgn ? ($signed(cnt) >= $signed(act[I_END])) : (cnt >= act[I_END]);
  wire [CW-1:0] nxt = beyond ? act[I_ST] : cnt + 1'b1;

  wire opp  = tick && ((lmode[0] && cnt == act[I_MID]) || (lmode[1] && beyond));
  wire hit  = opp && (fq_cnt == ldfq);
  wire do_load = load_ok && (imm || hit);
  wire ldok_wr = wr_en && (wr_addr == A_LDOK) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        stg[i] <= '0;
        act[i] <= '0;
      end
      ctl  <= '0;
      octl <= '0;
    end else begin
      if (wr_en && wr_addr < AW'(NREG)) stg[wr_addr[2:0]] <= wr_data;
      if (wr_en && wr_addr == A_CTL) ctl <= wr_data[CTW-1:0];
      if (wr_en && wr_addr == A_OUT) octl <= wr_data[3:0];
      if (do_load)
        for (int i = 0; i < NREG; i++) act[i] <= stg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_ok <= 1'b0;
    else if (ldok_wr) load_ok <= 1'b1;
    else if (do_load) load_ok <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre <= '0;
    else if (!run || tick) pre <= '0;
    else                  pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fq_cnt <= '0;
    else if (!run)   fq_cnt <= '0;
    else if (opp)    fq_cnt <= hit ? '0 : fq_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ra  <= 1'b0;
      rb  <= 1'b0;
    end else if (!run) begin
      cnt <= act[I_ST];
      ra  <= 1'b0;
      rb  <= 1'b0;
    end else if (tick) begin
      cnt <= nxt;
      if (nxt == act[I_AOFF])     ra <= 1'b0;
      else if (nxt == act[I_AON]) ra <= 1'b1;
      if (nxt == act[I_BOFF])     rb <= 1'b0;
      else if (nxt == act[I_BON]) rb <= 1'b1;
    end
  end

  wire pa = (indep || !src_b) ? ra : ~rb;
  wire pb = (indep || src_b) ? rb : ~ra;
  assign out_a = octl[2] & (pa ^ octl[0]);
  assign out_b = octl[3] & (pb ^ octl[1]);
endmodule

module pwm_submod_chk #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          out_a,
  input logic          out_b,
  input logic          run,
  input logic          indep,
  input logic [3:0]    octl,
  input logic          imm,
  input logic          load_ok,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] end_v,
  input logic [CW-1:0] start_v
);
  // R2
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == end_v) |=> (cnt == $past(start_v)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == $past(start_v)));
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !imm && load_ok) |=> load_ok);
  // R8
  imm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm && load_ok && !(wr_en && wr_addr == AW'(9))) |=> !load_ok);
  // R11
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!octl[2] |-> !out_a) and (!octl[3] |-> !out_b)));
  // R10
  comp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!indep && octl[2] && octl[3] && (octl[0] == octl[1])) |-> (out_a != out_b));
endmodule

bind pwm_submod pwm_submod_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .out_a(out_a), .out_b(out_b), .run(run), .indep(indep), .octl(octl),
  .imm(imm), .load_ok(load_ok), .tick(tick), .cnt(cnt),
  .end_v(act[2]), .start_v(act[0])
);

// File: tb/pwm_submod_tb.sv
module pwm_submod_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic out_a, out_b;

  always #10 clk = ~clk;

  pwm_submod dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .out_a(out_a), .out_b(out_b));

  typedef struct {int hi; int per; int on_b; string req;} exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // ctrl: [2:0] ps, [4:3] mode, [8:5] freq, 9 signed, 10 indep, 11 src_b, 12 run
  task automatic set_ctl(int ps, int mode, int fq, int sgn, int ind, int srcb, int run);
    int v = ps | (mode << 3) | (fq << 5) | (sgn << 9) | (ind << 10) | (srcb << 11) | (run << 12);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'(v);
    running = run[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stage(int st, int md, int en, int aon, int aoff, int bon, int boff);
    reg_wr(0, st); reg_wr(1, md); reg_wr(2, en);
    reg_wr(3, aon); reg_wr(4, aoff); reg_wr(5, bon); reg_wr(6, boff);
  endtask

  task automatic push(int hi, int per, int on_b, string req);
    exp_t e;
    e.hi = hi; e.per = per; e.on_b = on_b; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic hold_level(bit is_b, bit lvl, int n, string req);
    int bad = 0;
    bit v;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v = is_b ? out_b : out_a;
      if (v != lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic restore_edge();
    set_ctl(0, 0, 0, 0, 1, 0, 0);
    stage(0, 4, 7, 2, 6, 1, 1);
    reg_wr(9, 1);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pulse width and rise-to-rise period per output
  int cyc = 0;
  bit prv[2], arm[2];
  int rt[2], hl[2];
  initial begin
    bit cur[2];
    exp_t e;
    forever begin
      @(negedge clk);
      cyc++;
      cur[0] = out_a; cur[1] = out_b;
      for (int k = 0; k < 2; k++) begin
        if (!running) arm[k] = 1'b0;
        else if (cur[k] && !prv[k]) begin
          if (arm[k] && q.size() > 0 && q[0].on_b == k) begin
            e = q.pop_front();
            chk(hl[k] == e.hi, {e.req, " high"}, hl[k], e.hi);
            chk(cyc - rt[k] == e.per, {e.req, " period"}, cyc - rt[k], e.per);
          end
          arm[k] = 1'b1;
          rt[k] = cyc;
        end else if (!cur[k] && prv[k]) hl[k] = cyc - rt[k];
        prv[k] = cur[k];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_a == 1'b0, "R1 out_a", out_a, 0);
    chk(out_b == 1'b0, "R1 out_b", out_b, 0);

    reg_wr(8, 4'b1100);
    // R4 edge aligned, immediate load, B equal compares -> 0%
    restore_edge();
    push(4, 8, 0, "R4"); push(4, 8, 0, "R4");
    set_ctl(0, 0, 0, 0, 1, 0, 1);
    hold_level(1, 0, 40, "R4 zero duty B");
    drain();
    set_ctl(0, 0, 0, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    // R2 stopped outputs inactive
    hold_level(0, 0, 10, "R2 stopped A");

    // R6/R7 staged value without load request is ignored
    reg_wr(4, 4);
    repeat (3) @(negedge clk);
    push(4, 8, 0, "R6"); push(4, 8, 0, "R7");
    set_ctl(0, 0, 0, 0, 1, 0, 1);
    drain();

    // R9 freq field ignored in immediate mode
    set_ctl(0, 0, 3, 0, 1, 0, 0);
    reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(2, 8, 0, "R9 imm"); push(2, 8, 0, "R9 imm");
    set_ctl(0, 0, 3, 0, 1, 0, 1);
    drain();

    // R8 full-cycle reload, every third point (R9)
    restore_edge();
    set_ctl(0, 2, 2, 0, 1, 0, 0);
    reg_wr(4, 4); reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(4, 8, 0, "R9 full"); push(4, 8, 0, "R9 full"); push(4, 8, 0, "R7 pending");
    push(2, 8, 0, "R8 full");
    set_ctl(0, 2, 2, 0, 1, 0, 1);
    drain();

    // R8 half-cycle reload
    restore_edge();
    set_ctl(0, 1, 0, 0, 1, 0, 0);
    reg_wr(4, 4); reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(10, 16, 0, "R8 half"); push(2, 8, 0, "R8 half");
    set_ctl(0, 1, 0, 0, 1, 0, 1);
    drain();

    // R8 both points, every second (R9)
    restore_edge();
    set_ctl(0, 3, 1, 0, 1, 0, 0);
    reg_wr(4, 4); reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(4, 8, 0, "R8 both"); push(2, 8, 0, "R9 both");
    set_ctl(0, 3, 1, 0, 1, 0, 1);
    drain();

    // R3 prescale by 4
    restore_edge();
    push(16, 32, 0, "R3"); push(16, 32, 0, "R3");
    set_ctl(2, 0, 0, 0, 1, 0, 1);
    drain();

    // R5 signed centre aligned: start -8, end 7, on -3, off 3
    set_ctl(0, 0, 0, 1, 1, 0, 0);
    stage(16'hFFF8, 0, 7, 16'hFFFD, 3, 1, 1);
    reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(6, 16, 0, "R5 signed"); push(6, 16, 0, "R5 signed");
    set_ctl(0, 0, 0, 1, 1, 0, 1);
    drain();
    set_ctl(0, 0, 0, 0, 1, 0, 0);
    set_ctl(0, 0, 0, 0, 1, 0, 1);
    hold_level(0, 0, 64, "R5 unsigned stuck");
    set_ctl(0, 0, 0, 0, 1, 0, 0);

    // R4 unsigned centre aligned, period 16
    stage(0, 8, 15, 5, 11, 1, 1);
    reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(6, 16, 0, "R4 centre"); push(6, 16, 0, "R4 centre");
    set_ctl(0, 0, 0, 0, 1, 0, 1);
    drain();

    // R10 complementary, A source
    set_ctl(0, 0, 0, 0, 0, 0, 0);
    stage(0, 4, 7, 2, 5, 2, 5);
    reg_wr(9, 1);
    repeat (3) @(negedge clk);
    push(5, 8, 1, "R10 srcA"); push(5, 8, 1, "R10 srcA");
    set_ctl(0, 0, 0, 0, 0, 0, 1);
    drain();
    begin
      int bad = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (out_a == out_b) bad++;
      end
      chk(bad == 0, "R10 inverse", bad, 0);
    end
    // R10 complementary, B source
    set_ctl(0, 0, 0, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    push(5, 8, 0, "R10 srcB"); push(5, 8, 0, "R10 srcB");
    set_ctl(0, 0, 0, 0, 0, 1, 1);
    drain();

    // R11 polarity on A
    set_ctl(0, 0, 0, 0, 1, 0, 0);
    reg_wr(8, 4'b1101);
    repeat (2) @(negedge clk);
    push(5, 8, 0, "R11 pol"); push(5, 8, 0, "R11 pol");
    set_ctl(0, 0, 0, 0, 1, 0, 1);
    drain();
    // R11 disabled A held low while running
    reg_wr(8, 4'b1001);
    hold_level(0, 0, 32, "R11 disable");
    set_ctl(0, 0, 0, 0, 1, 0, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule